// File: doc/BRIEF.md
# OTP Nibble Write Command Handler

This block takes a deframed write-to-nonvolatile-memory command from a sensor bus and decides whether the device answers it. An accepted command loads a 4-bit value into one of sixteen mirror nibbles. If programming is armed, it also burns the same value into a sixteen-nibble one-time-programmable array. In that array a bit can only change from 0 to 1. Programming takes time in proportion to the number of bits that actually flip, and `busy` covers that time. When the work is done, a 16-bit response word is presented for one cycle.

The device address is not a separate input. It lives in one mirror nibble (parameter `DEV_NIB`, default nibble 0), and the reset image `OTP_INIT` gives its starting value. A command that rewrites that nibble therefore re-addresses the device, and the response to that command already carries the new address. A separate initialisation path arms programming with `nv_set` and latches a 2-bit bank. Every accepted command disarms programming. A check value over the mirror nibbles is compared with the value of the reset image. A difference raises `crc_err`, but only while `cfg_lock` is high.

Top module: `otp_nibble_writer`

## Requirements
- R1: After reset, `busy` and `resp_valid` are 0, `dev_addr` equals nibble `DEV_NIB` of `OTP_INIT` (4'h5 by default), and `crc_err` is 0.
- R2: A command is accepted only if all of these hold:
  - `cmd_code` is 4'b1001.
  - `cmd_fmt` is 1 (standard long) or 2 (enhanced long). Values 0 and 3 are other formats.
  - `cmd_addr` equals `dev_addr`.

  Any other command causes no response, no `busy`, no change to `dev_addr`, and leaves the programming arm set.
- R3: While `dev_addr` is 4'h0 (the global address), every command is ignored.
- R4: An accepted command loads `cmd_rd` into mirror nibble `cmd_wa`, whether or not programming is armed.
- R5: If programming is armed at acceptance, `busy` rises in the cycle after acceptance and stays high for BIT_CYCLES (default 4) cycles per programmed bit. `resp_valid` pulses for one cycle as `busy` falls. If no bit is programmed, or programming is not armed, there is no `busy` and `resp_valid` pulses in the cycle after acceptance.
- R6: The number of programmed bits is the count of bits set in `cmd_rd` that are still 0 in the fuse nibble `cmd_wa`. Burnt bits stay 1, so a repeated write programs nothing new.
- R7: `nv_set` arms programming and latches `bank_in`. An accepted command disarms it.
- R8: Response word layout:
  - [15:12] is `cmd_wa`.
  - [11:8] is the mirror nibble after the write.
  - [7] is the arm state at acceptance.
  - [6] is 0.
  - [5:4] is the latched bank when armed, otherwise 00.
  - [3:0] is the device address after the write.
- R9: A write to nibble `DEV_NIB` changes `dev_addr` to `cmd_rd`. The response reports the new address, and later commands must use it.
- R10: `crc_err` is high exactly when `cfg_lock` is 1 and the CRC-4 (polynomial x^4+x+1) of the mirror differs from that of `OTP_INIT`. Any change to a single nibble always changes this CRC.
- R11: A command presented while `busy` is high is dropped and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command fields valid this cycle |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | 4 | Target device address |
| cmd_fmt | input | 2 | Frame format: 0 short, 1 standard long, 2 enhanced long, 3 other |
| cmd_wa | input | 4 | Nibble index to write |
| cmd_rd | input | 4 | Nibble value to write |
| nv_set | input | 1 | Arm programming and latch bank |
| bank_in | input | 2 | Bank selected by the initialisation path |
| cfg_lock | input | 1 | Enables the configuration check flag |
| busy | output | 1 | Programming in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_word | output | 16 | Response word, valid with `resp_valid` |
| dev_addr | output | 4 | Current device address (mirror nibble `DEV_NIB`) |
| crc_err | output | 1 | Mirror check value differs while locked |

## Verification
The assertions take three things for granted:
- `cmd_valid` is low while `rst` is high.
- `nv_set` never arrives in the same cycle as an accepted command.
- The timer's start request never overlaps `busy`.

The stimulus meets the first two by driving all inputs on the falling edge. It pulses `nv_set` in a cycle of its own before each command, and it holds `cmd_valid` low for the whole reset.

// File: rtl/otpw_pkg.sv
package otpw_pkg;

    localparam int           NIB_W       = 4;
    localparam int           NIB_COUNT   = 2 ** NIB_W;
    localparam logic [3:0]   OP_NVM_WR   = 4'b1001;
    localparam logic [3:0]   GLOBAL_ADDR = 4'h0;
    localparam logic [3:0]   CRC_POLY    = 4'h3;

    typedef enum logic [1:0] {
        FMT_SHORT    = 2'd0,
        FMT_STD_LONG = 2'd1,
        FMT_ENH_LONG = 2'd2,
        FMT_OTHER    = 2'd3
    } frame_fmt_e;

    typedef struct packed {
        logic [3:0]       code;
        logic [3:0]       addr;
        frame_fmt_e       fmt;
        logic [NIB_W-1:0] wa;
        logic [3:0]       rd;
    } nvm_cmd_t;

    typedef struct packed {
        logic [NIB_W-1:0] wa;
        logic [3:0]       rdback;
        logic             nv;
        logic             zero;
        logic [1:0]       bank;
        logic [3:0]       addr;
    } nvm_resp_t;

    function automatic logic [2:0] bit_count4(input logic [3:0] v);
        return 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
    endfunction

    function automatic logic [3:0] crc4_step(input logic [3:0] c_in, input logic [3:0] nib);
        logic [3:0] c;
        logic       fb;
        c = c_in;
        for (int i = 3; i >= 0; i--) begin
            fb = c[3] ^ nib[i];
            c  = {c[2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/otpw_filter.sv
module otpw_filter
    import otpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  nvm_cmd_t   cmd,
    input  logic       busy,
    input  logic [3:0] cur_addr,
    output logic       accept
);

    logic fmt_ok;
    logic addr_ok;

    always_comb begin
        fmt_ok  = (cmd.fmt == FMT_STD_LONG) || (cmd.fmt == FMT_ENH_LONG);
        addr_ok = (cur_addr != GLOBAL_ADDR) && (cmd.addr == cur_addr);
        accept  = cmd_valid && !busy && (cmd.code == OP_NVM_WR) && fmt_ok && addr_ok;
    end

    // R3
    global_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_addr == GLOBAL_ADDR) |-> !accept);

endmodule

// File: rtl/otpw_store.sv
module otpw_store
    import otpw_pkg::*;
#(
    parameter int                         DEV_NIB  = 0,
    parameter logic [NIB_COUNT*4-1:0]     OTP_INIT = '0
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [NIB_W-1:0] wa,
    input  logic [3:0]       rd,
    input  logic             nv_set,
    input  logic [1:0]       bank_in,
    output logic             nv_q,
    output logic [1:0]       bank_q,
    output logic [3:0]       dev_addr,
    output logic [3:0]       next_addr,
    output logic [2:0]       new_bit_cnt,
    output logic             crc_diff
);

    function automatic logic [3:0] crc_of(input logic [NIB_COUNT*4-1:0] img);
        logic [3:0] c;
        c = '0;
        for (int i = 0; i < NIB_COUNT; i++) c = crc4_step(c, img[i*4 +: 4]);
        return c;
    endfunction

    localparam logic [3:0]       CRC_REF  = crc_of(OTP_INIT);
    localparam logic [NIB_W-1:0] ADDR_NIB = NIB_W'(DEV_NIB);

    logic [3:0] mirror_q [NIB_COUNT];
    logic [3:0] otp_q    [NIB_COUNT];
    logic [3:0] fresh_bits;
    logic [3:0] crc_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NIB_COUNT; i++) begin
                mirror_q[i] <= OTP_INIT[i*4 +: 4];
                otp_q[i]    <= OTP_INIT[i*4 +: 4];
            end
        end else if (wr_en) begin
            mirror_q[wa] <= rd;
            if (nv_q) otp_q[wa] <= otp_q[wa] | rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q   <= 1'b0;
            bank_q <= 2'b00;
        end else if (nv_set) begin
            nv_q   <= 1'b1;
            bank_q <= bank_in;
        end else if (wr_en) begin
            nv_q   <= 1'b0;
        end
    end

    always_comb begin
        dev_addr    = mirror_q[ADDR_NIB];
        next_addr   = (wa == ADDR_NIB) ? rd : mirror_q[ADDR_NIB];
        fresh_bits  = nv_q ? (rd & ~otp_q[wa]) : 4'b0000;
        new_bit_cnt = bit_count4(fresh_bits);
    end

    always_comb begin
        crc_now = '0;
        for (int i = 0; i < NIB_COUNT; i++) crc_now = crc4_step(crc_now, mirror_q[i]);
        crc_diff = (crc_now != CRC_REF);
    end

    // R4
    mirror_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mirror_q[$past(wa)] == $past(rd)));

    // R6
    fuse_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((otp_q[$past(wa)] & $past(otp_q[wa])) == $past(otp_q[wa])));

    // R7
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !nv_set) |=> !nv_q);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(dev_addr));

    // R10
    check_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(crc_diff));

endmodule

// File: rtl/otpw_prog_timer.sv
module otpw_prog_timer #(
    parameter int BIT_CYCLES = 4
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] nbits,
    output logic       busy,
    output logic       done
);

    localparam int CW = $clog2(4 * BIT_CYCLES + 1);

    typedef enum logic {T_IDLE, T_PROG} tstate_e;

    tstate_e       st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= T_IDLE;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                T_IDLE: if (start) begin
                    if (nbits == 3'd0) begin
                        done <= 1'b1;
                    end else begin
                        st_q  <= T_PROG;
                        cnt_q <= CW'(int'(nbits) * BIT_CYCLES - 1);
                    end
                end
                T_PROG: if (cnt_q == '0) begin
                    st_q <= T_IDLE;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= T_IDLE;
            endcase
        end
    end

    assign busy = (st_q == T_PROG);

    // R5
    quiet_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R5
    done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R11
    no_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/otp_nibble_writer.sv
module otp_nibble_writer
    import otpw_pkg::*;
#(
    parameter int                     BIT_CYCLES = 4,
    parameter int                     DEV_NIB    = 0,
    parameter logic [NIB_COUNT*4-1:0] OTP_INIT   = 64'h0000_0000_0000_3005
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_code,
    input  logic [3:0]  cmd_addr,
    input  logic [1:0]  cmd_fmt,
    input  logic [3:0]  cmd_wa,
    input  logic [3:0]  cmd_rd,
    input  logic        nv_set,
    input  logic [1:0]  bank_in,
    input  logic        cfg_lock,
    output logic        busy,
    output logic        resp_valid,
    output logic [15:0] resp_word,
    output logic [3:0]  dev_addr,
    output logic        crc_err
);

    nvm_cmd_t  cmd;
    nvm_resp_t resp_q;
    logic      accept;
    logic      nv_q;
    logic [1:0] bank_q;
    logic [3:0] next_addr;
    logic [2:0] new_bit_cnt;
    logic       crc_diff;

    always_comb begin
        cmd.code = cmd_code;
        cmd.addr = cmd_addr;
        cmd.fmt  = frame_fmt_e'(cmd_fmt);
        cmd.wa   = cmd_wa;
        cmd.rd   = cmd_rd;
    end

    otpw_filter u_filter (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .busy      (busy),
        .cur_addr  (dev_addr),
        .accept    (accept)
    );

    otpw_store #(
        .DEV_NIB  (DEV_NIB),
        .OTP_INIT (OTP_INIT)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (accept),
        .wa          (cmd.wa),
        .rd          (cmd.rd),
        .nv_set      (nv_set),
        .bank_in     (bank_in),
        .nv_q        (nv_q),
        .bank_q      (bank_q),
        .dev_addr    (dev_addr),
        .next_addr   (next_addr),
        .new_bit_cnt (new_bit_cnt),
        .crc_diff    (crc_diff)
    );

    otpw_prog_timer #(
        .BIT_CYCLES (BIT_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .nbits (new_bit_cnt),
        .busy  (busy),
        .done  (resp_valid)
    );

    // The mirror nibble holds cmd.rd after the write, so it doubles as the read-back field.
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else if (accept) begin
            resp_q <= '{wa:     cmd.wa,
                        rdback: cmd.rd,
                        nv:     nv_q,
                        zero:   1'b0,
                        bank:   nv_q ? bank_q : 2'b00,
                        addr:   next_addr};
        end
    end

    assign resp_word = resp_q;
    assign crc_err   = cfg_lock & crc_diff;

    // R8
    resp_zero_bit_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_word[6] == 1'b0));

    // R8
    resp_bank_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_word[7]) |-> (resp_word[5:4] == 2'b00));

endmodule

// File: tb/otp_nibble_writer_test.sv
`timescale 1ns/1ps
module otp_nibble_writer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [3:0]  cmd_code, cmd_addr, cmd_wa, cmd_rd;
    logic [1:0]  cmd_fmt, bank_in;
    logic        nv_set, cfg_lock;
    logic        busy, resp_valid, crc_err;
    logic [15:0] resp_word;
    logic [3:0]  dev_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    otp_nibble_writer uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_fmt(cmd_fmt), .cmd_wa(cmd_wa), .cmd_rd(cmd_rd),
        .nv_set(nv_set), .bank_in(bank_in), .cfg_lock(cfg_lock), .busy(busy),
        .resp_valid(resp_valid), .resp_word(resp_word), .dev_addr(dev_addr),
        .crc_err(crc_err)
    );

    // {arm, bank, code, addr, fmt, wa, rd, resp expected, busy cycles, addr after, word}
    function automatic logic [47:0] mk(input logic a, input logic [1:0] b, input logic [3:0] c,
        input logic [3:0] ad, input logic [1:0] f, input logic [3:0] w, input logic [3:0] r,
        input logic er, input logic [5:0] eb, input logic [3:0] ea, input logic [15:0] ew);
        return {a, b, c, ad, f, w, r, er, eb, ea, ew};
    endfunction

    localparam int NV = 11;
    localparam logic [47:0] VEC [NV] = '{
        mk(1, 2'd2, 4'h9, 4'h5, 2'd1, 4'h3, 4'h6, 1, 6'd4,  4'h5, 16'h36A5),
        mk(0, 2'd0, 4'h9, 4'h5, 2'd2, 4'h7, 4'hF, 1, 6'd0,  4'h5, 16'h7F05),
        mk(1, 2'd1, 4'h9, 4'h5, 2'd1, 4'h3, 4'hF, 1, 6'd4,  4'h5, 16'h3F95),
        mk(1, 2'd3, 4'h9, 4'h5, 2'd2, 4'h9, 4'hB, 1, 6'd12, 4'h5, 16'h9BB5),
        mk(1, 2'd0, 4'h9, 4'h5, 2'd1, 4'h9, 4'hB, 1, 6'd0,  4'h5, 16'h9B85),
        mk(0, 2'd0, 4'h9, 4'h5, 2'd1, 4'h0, 4'hA, 1, 6'd0,  4'hA, 16'h0A0A),
        mk(0, 2'd0, 4'h9, 4'h5, 2'd1, 4'h2, 4'h1, 0, 6'd0,  4'hA, 16'h0000),
        mk(1, 2'd2, 4'h8, 4'hA, 2'd1, 4'h2, 4'h1, 0, 6'd0,  4'hA, 16'h0000),
        mk(0, 2'd0, 4'h9, 4'hA, 2'd0, 4'h2, 4'h1, 0, 6'd0,  4'hA, 16'h0000),
        mk(0, 2'd0, 4'h9, 4'hA, 2'd3, 4'h2, 4'h1, 0, 6'd0,  4'hA, 16'h0000),
        mk(0, 2'd0, 4'h9, 4'hA, 2'd1, 4'h1, 4'h3, 1, 6'd8,  4'hA, 16'h13AA)
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic arm(input logic [1:0] bk);
        nv_set = 1'b1; bank_in = bk;
        @(posedge clk); @(negedge clk);
        nv_set = 1'b0;
    endtask

    task automatic drive(input logic [3:0] c, input logic [3:0] ad, input logic [1:0] f,
                         input logic [3:0] w, input logic [3:0] r);
        cmd_valid = 1'b1; cmd_code = c; cmd_addr = ad; cmd_fmt = f; cmd_wa = w; cmd_rd = r;
    endtask

    task automatic observe(output int nbusy, output int nresp, output logic [15:0] word);
        nbusy = 0; nresp = 0; word = '0;
        for (int i = 0; i < 40; i++) begin
            if (busy) nbusy++;
            if (resp_valid) begin nresp++; word = resp_word; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int nb, nr;
        logic [15:0] w;
        rst = 1'b1; cmd_valid = 1'b0; nv_set = 1'b0; bank_in = '0; cfg_lock = 1'b1;
        cmd_code = '0; cmd_addr = '0; cmd_fmt = '0; cmd_wa = '0; cmd_rd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "busy", busy, 0);
        check("R1", "resp_valid", resp_valid, 0);
        check("R1", "dev_addr", dev_addr, 4'h5);
        check("R1", "crc_err", crc_err, 0);

        // Table: R2 R4 R5 R6 R7 R8 R9 coverage
        for (int k = 0; k < NV; k++) begin
            logic [47:0] v;
            v = VEC[k];
            if (v[47]) arm(v[46:45]);
            drive(v[44:41], v[40:37], v[36:35], v[34:31], v[30:27]);
            @(posedge clk); @(negedge clk);
            cmd_valid = 1'b0;
            observe(nb, nr, w);
            check("R5", $sformatf("vec %0d busy cycles", k), nb, v[25:20]);
            check("R2", $sformatf("vec %0d response count", k), nr, v[26]);
            if (v[26]) check("R8", $sformatf("vec %0d response word", k), w, v[15:0]);
            check("R9", $sformatf("vec %0d dev_addr", k), dev_addr, v[19:16]);
        end

        // R10 check flag follows lock
        check("R10", "crc_err locked after edits", crc_err, 1);
        cfg_lock = 1'b0; #1;
        check("R10", "crc_err unlocked", crc_err, 0);
        cfg_lock = 1'b1;

        // R11 commands during busy are dropped
        arm(2'd0);
        drive(4'h9, 4'hA, 2'd1, 4'hB, 4'hF);
        @(posedge clk); @(negedge clk);
        check("R11", "busy after accept", busy, 1);
        drive(4'h9, 4'hA, 2'd1, 4'h0, 4'h0);
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        observe(nb, nr, w);
        check("R11", "single response", nr, 1);
        check("R11", "response word", w, 16'hBF8A);
        check("R11", "dev_addr kept", dev_addr, 4'hA);

        // R3 move to global address, then everything is ignored
        drive(4'h9, 4'hA, 2'd1, 4'h0, 4'h0);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        observe(nb, nr, w);
        check("R9", "global write response", w, 16'h0000);
        check("R3", "dev_addr global", dev_addr, 4'h0);
        drive(4'h9, 4'h0, 2'd1, 4'h2, 4'h1);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        observe(nb, nr, w);
        check("R3", "no response at global", nr, 0);
        check("R3", "no busy at global", nb, 0);
        check("R3", "dev_addr still global", dev_addr, 4'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule